// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block is the 16-bit basic control register of a 10/100 Ethernet PHY, together with the small amount of control logic that its fields drive. A management agent writes a whole word through a single-cycle write strobe. It reads the current word back combinationally. Five stored fields drive the block's pins directly: loopback, isolate, power-down, forced speed and forced duplex. Auto-negotiation enable chooses whether the speed and duplex outputs follow the register or the negotiated result. Two command bits clear themselves, and each one is paced by a handshake from logic outside the block. The first requests a reset of the MII register group. The second requests a restart of auto-negotiation.

On the data side, the block sits between the line-side receive path and the MAC-facing MII receive pins. It can turn the transmit nibble straight back to the receive pins, and it can hold the receive pins quiet while the port is isolated. A collision-test generator raises COL a fixed number of bit-time ticks after TX_EN rises, and drops it a fixed number of ticks after TX_EN falls. Three state machines carry the behaviour:

- **Group reset:** `RST_IDLE` goes to `RST_BUSY` on a write with bit 15 set. It returns from `RST_BUSY` to `RST_IDLE` on `grp_rst_done`.
- **Auto-negotiation restart:** `AN_IDLE` goes to `AN_PEND` on a write that sets bit 9 while bit 12 is also set. It returns from `AN_PEND` to `AN_IDLE` on `an_started`, or when the group reset completes.
- **Collision test:**
  - `CT_IDLE` goes to `CT_WAIT` when TX_EN is high.
  - `CT_WAIT` goes to `CT_ON` on the last tick of the assert window, or back to `CT_IDLE` if TX_EN drops first.
  - `CT_ON` goes to `CT_HOLD` when TX_EN drops.
  - `CT_HOLD` goes back to `CT_ON` if TX_EN rises again, or to `CT_IDLE` on the last tick of the release window.
  - Every state goes to `CT_IDLE` when the test bit is clear.

Top module: `phy_ctl_reg`

## Requirements
- R1: After reset, the register reads 16'h3100: bit 13 (100 Mb/s) = 1, bit 12 (auto-negotiation on) = 1, bit 8 (full duplex) = 1, all other bits 0. Both `grp_rst_req` and `an_start_req` are low, and `col` is low.
- R2: A write with bit 15 = 1 raises `grp_rst_req`, and bit 15 reads 1, from the next cycle onward. Both stay high until the cycle after `grp_rst_done` is seen. In that cycle the register reads 16'h3100 again. Writes made while the reset is in progress change nothing.
- R3: Bits 6..0 always read 0, and whatever is written to them has no effect.
- R4: With bit 12 = 1, `spd_100` and `full_dpx` follow `an_spd_100` and `an_full_dpx`. With bit 12 = 0, they follow bit 13 and bit 8. The stored bits 13 and 8 read back as last written in both cases.
- R5: A write with bit 9 = 1 and bit 12 = 1 raises `an_start_req`, and bit 9 reads 1, from the next cycle. Both drop in the cycle after `an_started`. A write with bit 9 = 1 and bit 12 = 0 leaves both low.
- R6: While a restart is pending, a write with bit 9 = 0 does not cancel it.
- R7: With bit 14 = 1, `rxd` equals `txd` and the line `phy_col` is blocked. With bit 14 = 0, `rxd` follows `phy_rxd` and `col` follows `phy_col`.
- R8: Bit 10 drives `isolate_o`, and bit 11 drives `pwr_down_o`. While bit 10 = 1, `rxd` and `col` are 0, whatever the loopback setting.
- R9: With bit 7 = 1, `col` rises in the cycle after the 64th `bit_tick` that follows the edge at which TX_EN was first seen high. It falls in the cycle after the 2nd `bit_tick` that follows the edge at which TX_EN was first seen low.
- R10: If TX_EN drops before the 64th tick, the collision test raises no COL for that transmission.
- R11: Completing the group reset also cancels a pending auto-negotiation restart. It also returns the collision-test, loopback, isolate and power-down bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Current register value |
| grp_rst_req | output | 1 | MII register group reset in progress |
| grp_rst_done | input | 1 | Group reset has completed |
| an_start_req | output | 1 | Auto-negotiation restart pending |
| an_started | input | 1 | Auto-negotiation has started |
| an_spd_100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_full_dpx | input | 1 | Negotiated duplex, 1 = full |
| spd_100 | output | 1 | Resolved speed |
| full_dpx | output | 1 | Resolved duplex |
| isolate_o | output | 1 | Port isolated from the MII |
| pwr_down_o | output | 1 | Power-down request |
| tx_en | input | 1 | MII transmit enable |
| txd | input | 4 | MII transmit nibble |
| phy_rxd | input | 4 | Receive nibble from the line side |
| phy_col | input | 1 | Collision from the line side |
| bit_tick | input | 1 | One pulse per bit time |
| rxd | output | 4 | MII receive nibble |
| col | output | 1 | MII collision |

## Verification
Completion of the group reset and start of auto-negotiation can land in the same cycle, while both handshakes are outstanding. The bench queues a restart request, opens a group reset behind it, and then pulses `grp_rst_done` and `an_started` on the same edge. Both request outputs must drop together on the next cycle, and the register must read its reset value with bit 9 clear. A second run completes the reset without any start, to show that the reset alone cancels the pending restart.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int REG_W        = 16;

    // Bit positions are fixed because management software decodes them.
    localparam int B_GRP_RST    = 15;
    localparam int B_LOOP       = 14;
    localparam int B_SPD        = 13;
    localparam int B_AN_EN      = 12;
    localparam int B_PDN        = 11;
    localparam int B_ISO        = 10;
    localparam int B_AN_RESTART = 9;
    localparam int B_DPX        = 8;
    localparam int B_COLTST     = 7;

    typedef enum logic {RST_IDLE, RST_BUSY} rst_state_t;
    typedef enum logic {AN_IDLE, AN_PEND} an_state_t;
    typedef enum logic [1:0] {CT_IDLE, CT_WAIT, CT_ON, CT_HOLD} ct_state_t;

    typedef struct packed {
        logic loopback;
        logic spd_100;
        logic an_en;
        logic pwr_down;
        logic isolate;
        logic full_dpx;
        logic coltst;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_DEFAULT = '{
        loopback: 1'b0, spd_100: 1'b1, an_en: 1'b1, pwr_down: 1'b0,
        isolate: 1'b0, full_dpx: 1'b1, coltst: 1'b0};

    function automatic ctl_fields_t fields_from_word(input logic [REG_W-1:0] w);
        ctl_fields_t f;
        f.loopback = w[B_LOOP];
        f.spd_100  = w[B_SPD];
        f.an_en    = w[B_AN_EN];
        f.pwr_down = w[B_PDN];
        f.isolate  = w[B_ISO];
        f.full_dpx = w[B_DPX];
        f.coltst   = w[B_COLTST];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] word_from_fields(input ctl_fields_t f);
        logic [REG_W-1:0] w;
        w           = '0;
        w[B_LOOP]   = f.loopback;
        w[B_SPD]    = f.spd_100;
        w[B_AN_EN]  = f.an_en;
        w[B_PDN]    = f.pwr_down;
        w[B_ISO]    = f.isolate;
        w[B_DPX]    = f.full_dpx;
        w[B_COLTST] = f.coltst;
        return w;
    endfunction

endpackage

// File: rtl/pctl_regs.sv
module pctl_regs
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             grp_rst_done,
    input  logic             an_started,
    input  logic             an_spd_100,
    input  logic             an_full_dpx,
    output ctl_fields_t      fields,
    output logic [REG_W-1:0] rd_data,
    output logic             grp_rst_req,
    output logic             an_start_req,
    output logic             spd_100,
    output logic             full_dpx
);

    rst_state_t  rst_q, rst_d;
    an_state_t   an_q, an_d;
    ctl_fields_t fld_q, fld_d;

    logic wr_ok;
    logic rst_finish;
    logic unused_rsvd;

    assign wr_ok       = wr_en && (rst_q == RST_IDLE);
    assign rst_finish  = (rst_q == RST_BUSY) && grp_rst_done;
    assign unused_rsvd = ^wr_data[6:0];

    // Group reset next-state logic.
    always_comb begin
        rst_d = rst_q;
        unique case (rst_q)
            RST_IDLE: if (wr_ok && wr_data[B_GRP_RST]) rst_d = RST_BUSY;
            RST_BUSY: if (grp_rst_done)                rst_d = RST_IDLE;
        endcase
    end

    // Auto-negotiation restart next-state logic.
    always_comb begin
        an_d = an_q;
        unique case (an_q)
            AN_IDLE: if (wr_ok && wr_data[B_AN_RESTART] && wr_data[B_AN_EN]) an_d = AN_PEND;
            AN_PEND: if (an_started || rst_finish)                          an_d = AN_IDLE;
        endcase
    end

    // Stored fields: defaults on reset completion, otherwise accepted writes.
    always_comb begin
        fld_d = fld_q;
        if (rst_finish)
            fld_d = CTL_DEFAULT;
        else if (wr_ok)
            fld_d = fields_from_word(wr_data);
    end

    // State registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q <= RST_IDLE;
            an_q  <= AN_IDLE;
            fld_q <= CTL_DEFAULT;
        end else begin
            rst_q <= rst_d;
            an_q  <= an_d;
            fld_q <= fld_d;
        end
    end

    // Outputs.
    always_comb begin
        fields       = fld_q;
        grp_rst_req  = (rst_q == RST_BUSY);
        an_start_req = (an_q == AN_PEND);
        rd_data               = word_from_fields(fld_q);
        rd_data[B_GRP_RST]    = grp_rst_req;
        rd_data[B_AN_RESTART] = an_start_req;
        spd_100  = fld_q.an_en ? an_spd_100  : fld_q.spd_100;
        full_dpx = fld_q.an_en ? an_full_dpx : fld_q.full_dpx;
    end

    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_rst_req && !grp_rst_done) |=> grp_rst_req);

    a_r2_done_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_rst_req && grp_rst_done) |=> (rd_data == 16'h3100));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'd0);

    a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_start_req) |-> $past(wr_en && wr_data[B_AN_RESTART] && wr_data[B_AN_EN]));

    a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start_req && !an_started && !(grp_rst_req && grp_rst_done)) |=> an_start_req);

endmodule

// File: rtl/pctl_coltest.sv
module pctl_coltest
    import pctl_pkg::*;
#(
    parameter int ON_TICKS  = 64,
    parameter int OFF_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_en,
    input  logic bit_tick,
    output logic col_gen
);

    localparam int MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
    localparam int CW   = $clog2(MAXT) + 1;

    ct_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable) begin
            st_d  = CT_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                CT_IDLE: if (tx_en) begin
                    st_d  = CT_WAIT;
                    cnt_d = '0;
                end
                CT_WAIT: begin
                    if (!tx_en)
                        st_d = CT_IDLE;
                    else if (bit_tick) begin
                        if (cnt_q == CW'(ON_TICKS - 1)) st_d = CT_ON;
                        else                            cnt_d = cnt_q + 1'b1;
                    end
                end
                CT_ON: if (!tx_en) begin
                    st_d  = CT_HOLD;
                    cnt_d = '0;
                end
                CT_HOLD: begin
                    if (tx_en)
                        st_d = CT_ON;
                    else if (bit_tick) begin
                        if (cnt_q == CW'(OFF_TICKS - 1)) st_d = CT_IDLE;
                        else                             cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        col_gen = (st_q == CT_ON) || (st_q == CT_HOLD);
    end

    a_r9_col_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_gen) |-> $past(tx_en && enable));

    a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_WAIT) |-> (cnt_q < CW'(ON_TICKS)));

    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_WAIT && !tx_en) |=> !col_gen);

endmodule

// File: rtl/pctl_mii_path.sv
module pctl_mii_path #(
    parameter int MII_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loopback,
    input  logic             isolate,
    input  logic             col_gen,
    input  logic [MII_W-1:0] txd,
    input  logic [MII_W-1:0] phy_rxd,
    input  logic             phy_col,
    output logic [MII_W-1:0] rxd,
    output logic             col
);

    always_comb begin
        if (isolate) begin
            rxd = '0;
            col = 1'b0;
        end else if (loopback) begin
            rxd = txd;
            col = col_gen;
        end else begin
            rxd = phy_rxd;
            col = col_gen | phy_col;
        end
    end

    a_r8_iso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |-> (rxd == '0 && !col));

    a_r7_loop_path: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && !isolate) |-> (rxd == txd));

endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
    import pctl_pkg::*;
#(
    parameter int MII_W     = 4,
    parameter int ON_TICKS  = 64,
    parameter int OFF_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    output logic             grp_rst_req,
    input  logic             grp_rst_done,
    output logic             an_start_req,
    input  logic             an_started,
    input  logic             an_spd_100,
    input  logic             an_full_dpx,
    output logic             spd_100,
    output logic             full_dpx,
    output logic             isolate_o,
    output logic             pwr_down_o,
    input  logic             tx_en,
    input  logic [MII_W-1:0] txd,
    input  logic [MII_W-1:0] phy_rxd,
    input  logic             phy_col,
    input  logic             bit_tick,
    output logic [MII_W-1:0] rxd,
    output logic             col
);

    ctl_fields_t fields;
    logic        col_gen;

    pctl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .grp_rst_done (grp_rst_done),
        .an_started   (an_started),
        .an_spd_100   (an_spd_100),
        .an_full_dpx  (an_full_dpx),
        .fields       (fields),
        .rd_data      (rd_data),
        .grp_rst_req  (grp_rst_req),
        .an_start_req (an_start_req),
        .spd_100      (spd_100),
        .full_dpx     (full_dpx)
    );

    pctl_coltest #(
        .ON_TICKS  (ON_TICKS),
        .OFF_TICKS (OFF_TICKS)
    ) u_coltest (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fields.coltst),
        .tx_en    (tx_en),
        .bit_tick (bit_tick),
        .col_gen  (col_gen)
    );

    pctl_mii_path #(
        .MII_W (MII_W)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .loopback (fields.loopback),
        .isolate  (fields.isolate),
        .col_gen  (col_gen),
        .txd      (txd),
        .phy_rxd  (phy_rxd),
        .phy_col  (phy_col),
        .rxd      (rxd),
        .col      (col)
    );

    assign isolate_o  = fields.isolate;
    assign pwr_down_o = fields.pwr_down;

    a_r8_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (isolate_o == rd_data[10]) && (pwr_down_o == rd_data[11]));

endmodule

// File: tb/sim_phy_ctl_reg.sv
`timescale 1ns/1ps
module sim_phy_ctl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        grp_rst_req, grp_rst_done = 1'b0;
    logic        an_start_req, an_started = 1'b0;
    logic        an_spd_100 = 1'b0, an_full_dpx = 1'b0;
    logic        spd_100, full_dpx, isolate_o, pwr_down_o;
    logic        tx_en = 1'b0;
    logic [3:0]  txd = '0, phy_rxd = '0, rxd;
    logic        phy_col = 1'b0, bit_tick = 1'b0, col;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phy_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .grp_rst_req(grp_rst_req), .grp_rst_done(grp_rst_done),
        .an_start_req(an_start_req), .an_started(an_started),
        .an_spd_100(an_spd_100), .an_full_dpx(an_full_dpx),
        .spd_100(spd_100), .full_dpx(full_dpx), .isolate_o(isolate_o), .pwr_down_o(pwr_down_o),
        .tx_en(tx_en), .txd(txd), .phy_rxd(phy_rxd), .phy_col(phy_col),
        .bit_tick(bit_tick), .rxd(rxd), .col(col)
    );

    // {wr16, an_spd, an_dpx, phy_rxd4, phy_col, txd4, exp_rxd4, exp_col, exp_spd, exp_dpx}
    localparam logic [33:0] VEC [8] = '{
        {16'h3100, 1'b0, 1'b1, 4'hA, 1'b1, 4'h5, 4'hA, 1'b1, 1'b0, 1'b1},
        {16'h0000, 1'b1, 1'b1, 4'h3, 1'b0, 4'hC, 4'h3, 1'b0, 1'b0, 1'b0},
        {16'h2100, 1'b0, 1'b0, 4'hF, 1'b1, 4'h1, 4'hF, 1'b1, 1'b1, 1'b1},
        {16'h4000, 1'b1, 1'b1, 4'h9, 1'b1, 4'h6, 4'h6, 1'b0, 1'b0, 1'b0},
        {16'h0C00, 1'b1, 1'b1, 4'h7, 1'b1, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0},
        {16'h4400, 1'b0, 1'b0, 4'h8, 1'b1, 4'hD, 4'h0, 1'b0, 1'b0, 1'b0},
        {16'h7100, 1'b1, 1'b0, 4'h2, 1'b1, 4'hB, 4'hB, 1'b0, 1'b1, 1'b0},
        {16'h207F, 1'b1, 1'b1, 4'h4, 1'b0, 4'hE, 4'h4, 1'b0, 1'b1, 1'b0}
    };

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick();
        bit_tick = 1'b1; step();
        bit_tick = 1'b0; step();
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h3100);
        chk("R1 grp_rst_req", {15'd0, grp_rst_req}, 16'd0);
        chk("R1 an_start_req", {15'd0, an_start_req}, 16'd0);
        chk("R1 col", {15'd0, col}, 16'd0);

        // Vector table: R3 R4 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [33:0] v;
            v = VEC[i];
            step();
            wr(v[33:18]);
            an_spd_100 = v[17]; an_full_dpx = v[16];
            phy_rxd = v[15:12]; phy_col = v[11]; txd = v[10:7];
            settle();
            chk($sformatf("R3 readback vec%0d", i), rd_data, v[33:18] & 16'h7D80);
            chk($sformatf("R7 rxd vec%0d", i), {12'd0, rxd}, {12'd0, v[6:3]});
            chk($sformatf("R7 col vec%0d", i), {15'd0, col}, {15'd0, v[2]});
            chk($sformatf("R4 spd vec%0d", i), {15'd0, spd_100}, {15'd0, v[1]});
            chk($sformatf("R4 dpx vec%0d", i), {15'd0, full_dpx}, {15'd0, v[0]});
            chk($sformatf("R8 pins vec%0d", i), {14'd0, pwr_down_o, isolate_o},
                {14'd0, v[29], v[28]});
        end
        step();
        phy_col = 1'b0;

        // R5 / R6 restart handshake
        wr(16'h1200);
        settle();
        chk("R5 start req", {15'd0, an_start_req}, 16'd1);
        chk("R5 bit9 read", {15'd0, rd_data[9]}, 16'd1);
        step();
        wr(16'h1000);
        settle();
        chk("R6 write 0 keeps pending", {15'd0, an_start_req}, 16'd1);
        step();
        an_started = 1'b1; step(); an_started = 1'b0;
        settle();
        chk("R5 cleared after start", {15'd0, an_start_req, 6'd0, rd_data[9]}, 16'd0);
        step();
        wr(16'h0200);
        settle();
        chk("R5 disabled ignores", {15'd0, an_start_req | rd_data[9]}, 16'd0);

        // R2 group reset
        step();
        wr(16'h8000);
        settle();
        chk("R2 req high", {15'd0, grp_rst_req}, 16'd1);
        chk("R2 bit15 read", {15'd0, rd_data[15]}, 16'd1);
        step();
        wr(16'h4000);
        settle();
        chk("R2 write ignored while busy", {15'd0, rd_data[14]}, 16'd0);
        step();
        grp_rst_done = 1'b1; step(); grp_rst_done = 1'b0;
        settle();
        chk("R2 defaults after done", rd_data, 16'h3100);
        chk("R2 req low", {15'd0, grp_rst_req}, 16'd0);

        // Concurrent completion: reset done and AN start in the same cycle (R2 R5)
        step();
        wr(16'h1200);
        wr(16'h8000);
        grp_rst_done = 1'b1; an_started = 1'b1;
        step();
        grp_rst_done = 1'b0; an_started = 1'b0;
        settle();
        chk("R5 concurrent an clear", {15'd0, an_start_req}, 16'd0);
        chk("R2 concurrent rd", rd_data, 16'h3100);

        // R11 reset alone cancels pending restart and clears fields
        step();
        wr(16'h1E80);
        wr(16'h8000);
        grp_rst_done = 1'b1; step(); grp_rst_done = 1'b0;
        settle();
        chk("R11 pending cancelled", {15'd0, an_start_req}, 16'd0);
        chk("R11 fields default", rd_data, 16'h3100);

        // R9 collision test timing
        step();
        wr(16'h0080);
        tx_en = 1'b1;
        step();
        for (int k = 0; k < 63; k++) tick();
        settle();
        chk("R9 col low after 63 ticks", {15'd0, col}, 16'd0);
        step();
        tick();
        settle();
        chk("R9 col high after 64 ticks", {15'd0, col}, 16'd1);
        step();
        tx_en = 1'b0;
        step();
        tick();
        settle();
        chk("R9 col held after 1 tick", {15'd0, col}, 16'd1);
        step();
        tick();
        settle();
        chk("R9 col low after 2 ticks", {15'd0, col}, 16'd0);

        // R10 abort before the window closes
        step();
        tx_en = 1'b1;
        step();
        for (int k = 0; k < 20; k++) tick();
        tx_en = 1'b0;
        step();
        for (int k = 0; k < 70; k++) tick();
        settle();
        chk("R10 no col after abort", {15'd0, col}, 16'd0);

        step();
        summary();
    end

endmodule